// File: doc/BRIEF.md
# Watchdog Timer with Write-Once Timeout Rate

This block is a computer-operating-properly watchdog that runs from the bus E clock. A fixed prescaler divides the clock by 2^PRE_BITS, and its tick drives a timeout counter. The counter's terminal count is set by a two-bit rate field, which adds a further divide of 1, 4, 16 or 64. If software does not service the watchdog before the count expires, the block raises a reset request for a single clock cycle. If it is still not serviced, the request repeats once every period.

Software sets the rate through a small register write port. In normal operation the field is locked down: it accepts only the first write, and only while a short window after reset is open. In the special (test) mode it can be rewritten at any time. Servicing is a two-write key sequence on the service address, and only a complete sequence restarts the count. An enable input holds the whole count still while it is low.

Top module: `cop_watchdog`

## Requirements
- R1: The timeout period is 2^PRE_BITS * 4^rate E-clock cycles. Rate 0 gives 1, rate 1 gives 4, rate 2 gives 16 and rate 3 gives 64 prescaler ticks. An unserviced count started by reset raises `rst_req` right after clock edge number period, counting the first edge with `rst` low as edge 1.
- R2: Synchronous reset clears the rate field to 0 and drives `rst_req` low.
- R3: A rate write is a write with `wr_sel`=0, and its value is `wr_data[1:0]`. With `special_mode` low, a rate write is accepted only if it is sampled on one of edges 1 to WIN_LEN after reset. Writes on later edges are ignored.
- R4: With `special_mode` low, only the first accepted rate write takes effect, including a write of 0. Later rate writes are ignored.
- R5: With `special_mode` high, rate writes take effect at any time and any number of times.
- R6: Service is a write of 0x55 followed by a write of 0xAA, both with `wr_sel`=1. The 0xAA write restarts the prescaler and the timeout count, so the next request follows period edges after the edge that took the 0xAA.
- R7: The 0xAA write does not restart the count if no 0x55 came before it, or if another service-address write came between the 0x55 and the 0xAA.
- R8: `rst_req` is high for exactly one cycle. If the watchdog stays unserviced, the request repeats every period cycles.
- R9: While `wdog_en` is low, the prescaler and timeout count hold their values and `rst_req` stays low. Counting resumes from the held values once `wdog_en` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | E clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = rate field, 1 = service key |
| wr_data | input | 8 | Write data |
| special_mode | input | 1 | High in special/test modes: rate field freely writable |
| wdog_en | input | 1 | Enables counting |
| rate_q | output | 2 | Current rate field |
| rst_req | output | 1 | One-cycle timeout reset request |

## Verification
The hardest conditions to reach are the two edges that bracket the end of the write window, edge WIN_LEN and edge WIN_LEN+1. Reaching them means counting clock edges exactly from the release of reset. The bench therefore drives every write through a single-cycle step task that keeps its own edge count from the release. It places rate writes on those two edges and on edges well before and after them. Timeout edges are predicted arithmetically from the prescaler width, the rate, the edge of the last complete service sequence and the number of edges with counting disabled. The bench runs a small prescaler so that all four rates, including the longest, can be swept to expiry.

// File: rtl/cop_pkg.sv
package cop_pkg;

    typedef enum logic [1:0] {
        RATE_DIV1  = 2'd0,
        RATE_DIV4  = 2'd1,
        RATE_DIV16 = 2'd2,
        RATE_DIV64 = 2'd3
    } rate_e;

    typedef enum logic {
        SVC_IDLE  = 1'b0,
        SVC_ARMED = 1'b1
    } svc_state_e;

    typedef struct packed {
        logic       we;
        logic       sel;
        logic [7:0] data;
    } bus_wr_t;

    localparam logic       SEL_RATE = 1'b0;
    localparam logic       SEL_SVC  = 1'b1;
    localparam logic [7:0] KEY_ARM  = 8'h55;
    localparam logic [7:0] KEY_FIRE = 8'hAA;

    localparam int TCNT_W = 6;

    // Number of prescaler ticks per timeout for a rate code.
    function automatic logic [TCNT_W:0] rate_ticks(rate_e r);
        return (TCNT_W+1)'(1) << (2 * int'(r));
    endfunction

endpackage

// File: rtl/cop_prescaler.sv
module cop_prescaler #(
    parameter int PRE_BITS = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic restart,
    output logic tick
);
    localparam logic [PRE_BITS-1:0] PRE_MAX = '1;

    logic [PRE_BITS-1:0] cnt;

    assign tick = en && (cnt == PRE_MAX);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9: a disabled prescaler holds its count
    a_r9_pre_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !restart) |=> $stable(cnt));

endmodule

// File: rtl/cop_rate_reg.sv
module cop_rate_reg
    import cop_pkg::*;
#(
    parameter int WIN_LEN = 64
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_wr_t wr,
    input  logic    special_mode,
    output rate_e   rate_o,
    output logic    win_open_o
);
    localparam int WIN_W = $clog2(WIN_LEN + 1);
    localparam logic [WIN_W-1:0] WIN_END = WIN_W'(WIN_LEN);

    logic [WIN_W-1:0] win_cnt;
    logic             written;
    logic             rate_wr;
    logic             accept;

    assign win_open_o = (win_cnt < WIN_END);
    assign rate_wr    = wr.we && (wr.sel == SEL_RATE);
    assign accept     = rate_wr && (special_mode || (win_open_o && !written));

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt <= '0;
        end else if (win_open_o) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_o  <= RATE_DIV1;
            written <= 1'b0;
        end else if (accept) begin
            rate_o  <= rate_e'(wr.data[1:0]);
            written <= 1'b1;
        end
    end

    a_r2_reset_rate: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rate_o == RATE_DIV1));

    a_r3_window_closed: assert property (@(posedge clk) disable iff (rst)
        (!win_open_o && !special_mode) |=> $stable(rate_o));

    a_r3_window_stays_closed: assert property (@(posedge clk) disable iff (rst)
        !win_open_o |=> !win_open_o);

    a_r4_single_write: assert property (@(posedge clk) disable iff (rst)
        (written && !special_mode) |=> $stable(rate_o));

endmodule

// File: rtl/cop_service.sv
module cop_service
    import cop_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_wr_t wr,
    output logic    clear_o
);
    svc_state_e state;
    logic       svc_wr;

    assign svc_wr  = wr.we && (wr.sel == SEL_SVC);
    assign clear_o = svc_wr && (wr.data == KEY_FIRE) && (state == SVC_ARMED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SVC_IDLE;
        end else if (svc_wr) begin
            state <= (wr.data == KEY_ARM) ? SVC_ARMED : SVC_IDLE;
        end
    end

    // R7: the key sequence never fires twice without re-arming
    a_r7_disarm_after_fire: assert property (@(posedge clk) disable iff (rst)
        clear_o |=> !clear_o);

endmodule

// File: rtl/cop_timeout.sv
module cop_timeout
    import cop_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  restart,
    input  rate_e rate,
    output logic  req_o
);
    logic [TCNT_W-1:0] tcnt;
    logic [TCNT_W:0]   last;
    logic              expire;

    assign last   = rate_ticks(rate) - 1'b1;
    assign expire = tick && ({1'b0, tcnt} >= last);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            tcnt  <= '0;
            req_o <= 1'b0;
        end else begin
            req_o <= expire;
            if (expire) begin
                tcnt <= '0;
            end else if (tick) begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        req_o |=> !req_o);

    a_r1_req_on_tick: assert property (@(posedge clk) disable iff (rst)
        req_o |-> $past(tick));

    a_r6_restart_zeroes: assert property (@(posedge clk) disable iff (rst)
        restart |=> (tcnt == '0 && !req_o));

endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
    import cop_pkg::*;
#(
    parameter int PRE_BITS = 15,
    parameter int WIN_LEN  = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       special_mode,
    input  logic       wdog_en,
    output logic [1:0] rate_q,
    output logic       rst_req
);
    bus_wr_t wr;
    rate_e   rate;
    logic    win_open;
    logic    svc_clear;
    logic    pre_tick;

    assign wr     = '{we: wr_en, sel: wr_sel, data: wr_data};
    assign rate_q = rate;

    cop_rate_reg #(.WIN_LEN(WIN_LEN)) u_rate (
        .clk          (clk),
        .rst          (rst),
        .wr           (wr),
        .special_mode (special_mode),
        .rate_o       (rate),
        .win_open_o   (win_open)
    );

    cop_service u_svc (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .clear_o (svc_clear)
    );

    cop_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .en      (wdog_en),
        .restart (svc_clear),
        .tick    (pre_tick)
    );

    cop_timeout u_tmo (
        .clk     (clk),
        .rst     (rst),
        .tick    (pre_tick),
        .restart (svc_clear),
        .rate    (rate),
        .req_o   (rst_req)
    );

    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !wdog_en |=> !rst_req);

    a_r6_service_quiet: assert property (@(posedge clk) disable iff (rst)
        svc_clear |=> !rst_req);

    a_r2_reset_no_req: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rst_req);

endmodule

// File: tb/cop_watchdog_tb.sv
module cop_watchdog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PRE_BITS   = 4;
    localparam int WIN_LEN    = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       special_mode = 1'b0;
    logic       wdog_en = 1'b1;
    logic [1:0] rate_q;
    logic       rst_req;

    int checks = 0;
    int fails  = 0;
    int cyc, pulses, first_p, last_p, wide;
    logic prev_req;
    int total_cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cop_watchdog #(.PRE_BITS(PRE_BITS), .WIN_LEN(WIN_LEN)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .special_mode(special_mode), .wdog_en(wdog_en),
        .rate_q(rate_q), .rst_req(rst_req)
    );

    function automatic int period(int r);
        return (1 << PRE_BITS) * (1 << (2 * r));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic spec);
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; wdog_en = 1'b1; special_mode = spec;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0; pulses = 0; first_p = 0; last_p = 0; wide = 0; prev_req = 1'b0;
    endtask

    // One clock edge; inputs are sampled at it, outputs observed after it.
    task automatic step(input logic we, input logic sel, input logic [7:0] d);
        wr_en = we; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        cyc++;
        if (rst_req) begin
            pulses++;
            if (first_p == 0) first_p = cyc;
            last_p = cyc;
            if (prev_req) wide++;
        end
        prev_req = rst_req;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00);
    endtask

    task automatic run_to(input int k);
        while (cyc < k) step(1'b0, 1'b0, 8'h00);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            total_cycles++;
            if (total_cycles > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d expected %0d", total_cycles, 150000);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        // R2: reset state
        do_reset(1'b0);
        chk(rate_q == 2'd0, "R2 rate after reset", rate_q, 0);
        chk(rst_req == 1'b0, "R2 req after reset", rst_req, 0);
        idle(1);
        chk(rst_req == 1'b0, "R2 req first cycle", rst_req, 0);

        // R1, R8: sweep all rates, two periods each
        for (int r = 0; r < 4; r++) begin
            do_reset(1'b0);
            step(1'b1, 1'b0, 8'(r));
            chk(rate_q == 2'(r), "R1 rate written", rate_q, r);
            run_to(2 * period(r) + 3);
            chk(first_p == period(r), "R1 first timeout edge", first_p, period(r));
            chk(pulses == 2, "R8 pulse count over two periods", pulses, 2);
            chk(last_p == 2 * period(r), "R8 repeat period", last_p, 2 * period(r));
            chk(wide == 0, "R8 one-cycle pulse", wide, 0);
        end

        // R3: window edges swept near the boundary
        for (int k = WIN_LEN - 2; k <= WIN_LEN + 2; k++) begin
            do_reset(1'b0);
            idle(k - 1);
            step(1'b1, 1'b0, 8'h03);
            chk(rate_q == ((k <= WIN_LEN) ? 2'd3 : 2'd0), "R3 window edge",
                rate_q, (k <= WIN_LEN) ? 3 : 0);
        end
        do_reset(1'b0);
        idle(200);
        step(1'b1, 1'b0, 8'h02);
        chk(rate_q == 2'd0, "R3 late write ignored", rate_q, 0);

        // R4: only the first write counts
        do_reset(1'b0);
        idle(4);
        step(1'b1, 1'b0, 8'h01);
        idle(4);
        step(1'b1, 1'b0, 8'h02);
        chk(rate_q == 2'd1, "R4 second write ignored", rate_q, 1);
        do_reset(1'b0);
        step(1'b1, 1'b0, 8'h00);
        step(1'b1, 1'b0, 8'h03);
        chk(rate_q == 2'd0, "R4 write of zero locks", rate_q, 0);
        // service writes are not rate writes
        do_reset(1'b0);
        step(1'b1, 1'b1, 8'h03);
        step(1'b1, 1'b0, 8'h02);
        chk(rate_q == 2'd2, "R4 service write does not consume", rate_q, 2);

        // R5: special mode rewrites at any time
        do_reset(1'b1);
        idle(100);
        for (int v = 0; v < 8; v++) begin
            step(1'b1, 1'b0, 8'((v * 3 + 1) % 4));
            chk(rate_q == 2'((v * 3 + 1) % 4), "R5 special rewrite", rate_q, (v * 3 + 1) % 4);
        end

        // R6: periodic service suppresses timeouts
        do_reset(1'b0);
        for (int i = 0; i < 30; i++) begin
            idle(8);
            step(1'b1, 1'b1, 8'h55);
            step(1'b1, 1'b1, 8'hAA);
        end
        chk(pulses == 0, "R6 serviced no timeout", pulses, 0);
        // R6: restart timing
        do_reset(1'b0);
        idle(9);
        step(1'b1, 1'b1, 8'h55);
        step(1'b1, 1'b1, 8'hAA);
        run_to(11 + period(0) + 2);
        chk(first_p == 11 + period(0), "R6 restart edge", first_p, 11 + period(0));

        // R7: incomplete sequences do not restart
        do_reset(1'b0);
        idle(4);
        step(1'b1, 1'b1, 8'hAA);
        run_to(period(0) + 2);
        chk(first_p == period(0), "R7 fire without arm", first_p, period(0));
        do_reset(1'b0);
        idle(4);
        step(1'b1, 1'b1, 8'h55);
        step(1'b1, 1'b1, 8'h12);
        step(1'b1, 1'b1, 8'hAA);
        run_to(period(0) + 2);
        chk(first_p == period(0), "R7 broken sequence", first_p, period(0));
        do_reset(1'b0);
        idle(4);
        step(1'b1, 1'b1, 8'h55);
        step(1'b1, 1'b1, 8'hAA);
        step(1'b1, 1'b1, 8'hAA);
        run_to(6 + period(0) + 2);
        chk(first_p == 6 + period(0), "R7 repeat fire needs rearm", first_p, 6 + period(0));

        // R9: disable holds the count
        do_reset(1'b0);
        wdog_en = 1'b0;
        idle(50);
        chk(pulses == 0, "R9 no pulse while disabled", pulses, 0);
        wdog_en = 1'b1;
        run_to(50 + period(0) + 2);
        chk(first_p == 50 + period(0), "R9 resumes from held count", first_p, 50 + period(0));
        do_reset(1'b0);
        idle(period(0) - 1);
        wdog_en = 1'b0;
        idle(10);
        chk(pulses == 0, "R9 disabled at expiry", pulses, 0);
        wdog_en = 1'b1;
        idle(2);
        chk(first_p == period(0) + 10, "R9 expiry after re-enable", first_p, period(0) + 10);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule